// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block works out where a 32-bit RISC core fetches next. Instructions are four bytes long. Each cycle the decoder can present the current program counter, a transfer-kind code, a raw offset field, the value of a source register and the floating-point compare flag. One clock later the unit returns four things: the next program counter, a flag saying whether control left the sequential path, a request to write a return address, and a flag for a register-jump target that is not word-aligned.

All PC-relative targets are based on the address of the following instruction, which is the current PC plus four. Conditional transfers test one register against zero, or test the floating-point flag. The register-jump kinds take the register value as the target. The two linking kinds always ask to write the sequential address into register 31. When the unit does not take a transfer, the next PC is the sequential address. All address arithmetic wraps modulo 2^32.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted request, `out_valid`, `taken`, `link_we` and `misalign` are 0 and `next_pc` and `link_val` are 0.
- R2: Kind 0 (no transfer), and every code from 9 to 15, gives `taken`=0 and `next_pc` = pc+4.
- R3: Kind 1 (branch if zero) is taken exactly when `rs_val` is 0. It then gives `next_pc` = pc+4 + sign-extended `offset[15:0]`; when not taken, pc+4.
- R4: Kind 2 (branch if nonzero) is taken exactly when `rs_val` is not 0, with the same target and fall-through rules as R3.
- R5: Kind 3 is taken when `fp_flag` is 1, and kind 4 is taken when `fp_flag` is 0. Both use the R3 target and fall-through rules.
- R6: Kind 5 (direct jump) and kind 7 (direct jump with link) are always taken, to pc+4 + sign-extended `offset[25:0]`.
- R7: Kind 6 (register jump) and kind 8 (register jump with link) are always taken, with `next_pc` = `rs_val`.
- R8: `link_we` is 1 only for kinds 7 and 8. In that case `link_val` = pc+4. `link_idx` is always 31.
- R9: `misalign` is 1 only for kinds 6 and 8 with `rs_val[1:0]` nonzero. The target is still passed through unchanged.
- R10: Outputs change one clock after a cycle in which `in_valid` is 1, with `out_valid` set. A cycle in which `in_valid` is 0 gives `out_valid`, `taken`, `link_we` and `misalign` all 0 on the next clock.
- R11: Target and link sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| pc | input | 32 | Address of the current instruction |
| xfer_kind | input | 4 | Transfer-kind code (see R2 to R9) |
| offset | input | 26 | Raw offset field; the low 16 bits are used for conditional kinds |
| rs_val | input | 32 | Source register value |
| fp_flag | input | 1 | Floating-point compare flag |
| out_valid | output | 1 | Result present |
| next_pc | output | 32 | Next fetch address |
| taken | output | 1 | A transfer left the sequential path |
| link_we | output | 1 | Return-address write request |
| link_idx | output | 5 | Destination register of the link write |
| link_val | output | 32 | Return address |
| misalign | output | 1 | Register-jump target is not word-aligned |

## Verification
The bench targets several corner cases, each chosen to catch a specific fault:
- **Negative offsets.** A design that zero-extends instead of sign-extending would jump forward by almost 64 KiB or 64 MiB.
- **Fall-through.** A design that bases the target on pc rather than pc+4 would be off by four, and a fall-through that returned pc would stall fetch.
- **Link write on a taken branch.** The bench checks that a taken conditional branch raises no link write. A unit that linked on every taken transfer would corrupt register 31.
- **Misaligned register targets.** Only register jumps may raise `misalign`; a misaligned value in `rs_val` during a direct jump must not.
- **Idle cycles.** An idle cycle must clear the registered result.
- **Wraparound.** Targets that cross the top of the address space check the modulo arithmetic.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [3:0] {
        XK_NONE        = 4'd0,
        XK_BR_ZERO     = 4'd1,
        XK_BR_NONZERO  = 4'd2,
        XK_BR_FP_TRUE  = 4'd3,
        XK_BR_FP_FALSE = 4'd4,
        XK_JMP         = 4'd5,
        XK_JMP_REG     = 4'd6,
        XK_JMP_LINK    = 4'd7,
        XK_JMP_REG_LNK = 4'd8
    } xfer_kind_e;

    typedef enum logic [1:0] {
        CT_REG_ZERO    = 2'd0,
        CT_REG_NONZERO = 2'd1,
        CT_FP_SET      = 2'd2,
        CT_FP_CLEAR    = 2'd3
    } cond_test_e;

    typedef enum logic [1:0] {
        TS_SEQ   = 2'd0,
        TS_SHORT = 2'd1,
        TS_LONG  = 2'd2,
        TS_REG   = 2'd3
    } tgt_src_e;

    typedef struct packed {
        logic       is_cond;
        cond_test_e test;
        tgt_src_e   src;
        logic       link;
    } xfer_ctl_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [3:0] kind,
    output xfer_ctl_t  ctl
);
    always_comb begin
        ctl.is_cond = 1'b0;
        ctl.test    = CT_REG_ZERO;
        ctl.src     = TS_SEQ;
        ctl.link    = 1'b0;
        case (kind)
            XK_BR_ZERO: begin
                ctl.is_cond = 1'b1;
                ctl.test    = CT_REG_ZERO;
                ctl.src     = TS_SHORT;
            end
            XK_BR_NONZERO: begin
                ctl.is_cond = 1'b1;
                ctl.test    = CT_REG_NONZERO;
                ctl.src     = TS_SHORT;
            end
            XK_BR_FP_TRUE: begin
                ctl.is_cond = 1'b1;
                ctl.test    = CT_FP_SET;
                ctl.src     = TS_SHORT;
            end
            XK_BR_FP_FALSE: begin
                ctl.is_cond = 1'b1;
                ctl.test    = CT_FP_CLEAR;
                ctl.src     = TS_SHORT;
            end
            XK_JMP: begin
                ctl.src     = TS_LONG;
            end
            XK_JMP_REG: begin
                ctl.src     = TS_REG;
            end
            XK_JMP_LINK: begin
                ctl.src     = TS_LONG;
                ctl.link    = 1'b1;
            end
            XK_JMP_REG_LNK: begin
                ctl.src     = TS_REG;
                ctl.link    = 1'b1;
            end
            default: begin
                ctl.src     = TS_SEQ;
            end
        endcase
    end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] rs_val,
    input  logic            fp_flag,
    input  cond_test_e      test,
    output logic            met
);
    logic reg_is_zero;

    assign reg_is_zero = (rs_val == '0);

    always_comb begin
        case (test)
            CT_REG_ZERO:    met = reg_is_zero;
            CT_REG_NONZERO: met = !reg_is_zero;
            CT_FP_SET:      met = fp_flag;
            CT_FP_CLEAR:    met = !fp_flag;
            default:        met = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int XLEN         = 32,
    parameter int SHORT_W      = 16,
    parameter int LONG_W       = 26,
    parameter int INSTR_BYTES  = 4,
    parameter bit SHARED_ADDER = 1'b1
) (
    input  logic [XLEN-1:0]   pc,
    input  logic [LONG_W-1:0] offset,
    input  logic              use_long,
    output logic [XLEN-1:0]   seq_pc,
    output logic [XLEN-1:0]   rel_pc
);
    localparam int SHORT_PAD = XLEN - SHORT_W;
    localparam int LONG_PAD  = XLEN - LONG_W;

    logic [XLEN-1:0] sext_short;
    logic [XLEN-1:0] sext_long;

    assign seq_pc     = pc + XLEN'(INSTR_BYTES);
    assign sext_short = {{SHORT_PAD{offset[SHORT_W-1]}}, offset[SHORT_W-1:0]};
    assign sext_long  = {{LONG_PAD{offset[LONG_W-1]}}, offset};

    generate
        if (SHARED_ADDER) begin : g_shared
            logic [XLEN-1:0] picked;
            assign picked = use_long ? sext_long : sext_short;
            assign rel_pc = seq_pc + picked;
        end else begin : g_split
            logic [XLEN-1:0] sum_short;
            logic [XLEN-1:0] sum_long;
            assign sum_short = seq_pc + sext_short;
            assign sum_long  = seq_pc + sext_long;
            assign rel_pc    = use_long ? sum_long : sum_short;
        end
    endgenerate
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int XLEN         = 32,
    parameter int SHORT_W      = 16,
    parameter int LONG_W       = 26,
    parameter int INSTR_BYTES  = 4,
    parameter int REG_AW       = 5,
    parameter int LINK_REG     = 31,
    parameter bit SHARED_ADDER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [XLEN-1:0]   pc,
    input  logic [3:0]        xfer_kind,
    input  logic [LONG_W-1:0] offset,
    input  logic [XLEN-1:0]   rs_val,
    input  logic              fp_flag,
    output logic              out_valid,
    output logic [XLEN-1:0]   next_pc,
    output logic              taken,
    output logic              link_we,
    output logic [REG_AW-1:0] link_idx,
    output logic [XLEN-1:0]   link_val,
    output logic              misalign
);
    localparam int ALIGN_BITS = $clog2(INSTR_BYTES);

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] npc;
        logic            taken;
        logic            link_we;
        logic [XLEN-1:0] link_val;
        logic            misalign;
    } npc_state_t;

    npc_state_t st_d, st_q;
    xfer_ctl_t  ctl;
    logic       cond_met;
    logic [XLEN-1:0] seq_pc, rel_pc;

    npc_decode u_decode (
        .kind (xfer_kind),
        .ctl  (ctl)
    );

    npc_cond #(.XLEN(XLEN)) u_cond (
        .rs_val  (rs_val),
        .fp_flag (fp_flag),
        .test    (ctl.test),
        .met     (cond_met)
    );

    npc_target #(
        .XLEN         (XLEN),
        .SHORT_W      (SHORT_W),
        .LONG_W       (LONG_W),
        .INSTR_BYTES  (INSTR_BYTES),
        .SHARED_ADDER (SHARED_ADDER)
    ) u_target (
        .pc       (pc),
        .offset   (offset),
        .use_long (ctl.src == TS_LONG),
        .seq_pc   (seq_pc),
        .rel_pc   (rel_pc)
    );

    always_comb begin
        logic go;
        st_d          = st_q;
        st_d.valid    = in_valid;
        st_d.taken    = 1'b0;
        st_d.link_we  = 1'b0;
        st_d.misalign = 1'b0;
        go = (ctl.src != TS_SEQ) && (!ctl.is_cond || cond_met);
        if (in_valid) begin
            st_d.taken    = go;
            st_d.link_we  = ctl.link;
            st_d.link_val = seq_pc;
            if (!go) begin
                st_d.npc = seq_pc;
            end else if (ctl.src == TS_REG) begin
                st_d.npc      = rs_val;
                st_d.misalign = (rs_val[ALIGN_BITS-1:0] != '0);
            end else begin
                st_d.npc = rel_pc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign next_pc   = st_q.npc;
    assign taken     = st_q.taken;
    assign link_we   = st_q.link_we;
    assign link_idx  = REG_AW'(LINK_REG);
    assign link_val  = st_q.link_val;
    assign misalign  = st_q.misalign;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int XLEN        = 32,
    parameter int INSTR_BYTES = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [XLEN-1:0] pc,
    input logic [3:0]      xfer_kind,
    input logic [XLEN-1:0] rs_val,
    input logic            out_valid,
    input logic [XLEN-1:0] next_pc,
    input logic            taken,
    input logic            link_we,
    input logic [XLEN-1:0] link_val,
    input logic            misalign
);
    localparam int ALIGN_BITS = $clog2(INSTR_BYTES);

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r10_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !taken && !link_we && !misalign));
    a_r2_fallthrough_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && xfer_kind == 4'd0) |=> (!taken && next_pc == $past(pc) + XLEN'(INSTR_BYTES)));
    a_r7_reg_target: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && xfer_kind == 4'd6) |=> (taken && next_pc == $past(rs_val)));
    a_r6_direct_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && xfer_kind == 4'd5) |=> taken);
    a_r8_link_value: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (out_valid && link_val == $past(pc) + XLEN'(INSTR_BYTES)));
    a_r8_link_only_kinds: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && xfer_kind != 4'd7 && xfer_kind != 4'd8) |=> !link_we);
    a_r9_misalign_shape: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (out_valid && taken && next_pc[ALIGN_BITS-1:0] != '0));
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .INSTR_BYTES(INSTR_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .pc        (pc),
    .xfer_kind (xfer_kind),
    .rs_val    (rs_val),
    .out_valid (out_valid),
    .next_pc   (next_pc),
    .taken     (taken),
    .link_we   (link_we),
    .link_val  (link_val),
    .misalign  (misalign)
);

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] pc = '0;
    logic [3:0]  xfer_kind = '0;
    logic [25:0] offset = '0;
    logic [31:0] rs_val = '0;
    logic        fp_flag = 1'b0;
    logic        out_valid, taken, link_we, misalign;
    logic [31:0] next_pc, link_val;
    logic [4:0]  link_idx;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    npc_unit u_npc_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc(pc),
        .xfer_kind(xfer_kind), .offset(offset), .rs_val(rs_val),
        .fp_flag(fp_flag), .out_valid(out_valid), .next_pc(next_pc),
        .taken(taken), .link_we(link_we), .link_idx(link_idx),
        .link_val(link_val), .misalign(misalign)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] sx16(input logic [25:0] o);
        return {{16{o[15]}}, o[15:0]};
    endfunction
    function automatic logic [31:0] sx26(input logic [25:0] o);
        return {{6{o[25]}}, o};
    endfunction

    task automatic run(input string req, input logic [3:0] k, input logic [31:0] p,
                       input logic [25:0] o, input logic [31:0] r, input logic f,
                       input logic [31:0] e_pc, input logic e_tk,
                       input logic e_lw, input logic e_mis);
        @(negedge clk);
        in_valid = 1'b1; xfer_kind = k; pc = p; offset = o; rs_val = r; fp_flag = f;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " valid"}, 32'(out_valid), 32'd1);
        chk({req, " next_pc"}, next_pc, e_pc);
        chk({req, " taken"}, 32'(taken), 32'(e_tk));
        chk({req, " link_we"}, 32'(link_we), 32'(e_lw));
        chk({req, " misalign"}, 32'(misalign), 32'(e_mis));
        if (e_lw) begin
            chk({req, " link_val"}, link_val, p + 32'd4);
            chk({req, " link_idx"}, 32'(link_idx), 32'd31);
        end
    endtask

    task automatic t_reset_r1();
        chk("R1 valid", 32'(out_valid), 0);
        chk("R1 taken", 32'(taken), 0);
        chk("R1 link_we", 32'(link_we), 0);
        chk("R1 misalign", 32'(misalign), 0);
        chk("R1 next_pc", next_pc, 0);
        chk("R1 link_val", link_val, 0);
    endtask

    task automatic t_none_r2();
        run("R2 none", 4'd0, 32'h0000_1000, 26'h3FF_FFFF, 32'd0, 1'b1, 32'h0000_1004, 0, 0, 0);
        run("R2 code9", 4'd9, 32'h0000_2000, 26'h000_0040, 32'd0, 1'b1, 32'h0000_2004, 0, 0, 0);
        run("R2 code15", 4'd15, 32'h0000_2100, 26'h000_0040, 32'd3, 1'b0, 32'h0000_2104, 0, 0, 0);
    endtask

    task automatic t_zero_r3();
        run("R3 taken fwd", 4'd1, 32'h0000_4000, 26'h000_0100, 32'd0, 0, 32'h0000_4004 + sx16(26'h100), 1, 0, 0);
        run("R3 taken back", 4'd1, 32'h0000_4000, 26'h3FF_FFF0, 32'd0, 0, 32'h0000_4004 + sx16(26'h3FF_FFF0), 1, 0, 0);
        run("R3 not taken", 4'd1, 32'h0000_4000, 26'h000_0100, 32'd1, 0, 32'h0000_4004, 0, 0, 0);
    endtask

    task automatic t_nonzero_r4();
        run("R4 taken", 4'd2, 32'h0000_5000, 26'h000_8000, 32'h8000_0000, 0, 32'h0000_5004 + sx16(26'h8000), 1, 0, 0);
        run("R4 not taken", 4'd2, 32'h0000_5000, 26'h000_8000, 32'd0, 0, 32'h0000_5004, 0, 0, 0);
    endtask

    task automatic t_fp_r5();
        run("R5 true taken", 4'd3, 32'h0000_6000, 26'h000_0020, 32'd0, 1, 32'h0000_6024, 1, 0, 0);
        run("R5 true fall", 4'd3, 32'h0000_6000, 26'h000_0020, 32'd0, 0, 32'h0000_6004, 0, 0, 0);
        run("R5 false taken", 4'd4, 32'h0000_6000, 26'h000_FFFC, 32'd0, 0, 32'h0000_6000, 1, 0, 0);
        run("R5 false fall", 4'd4, 32'h0000_6000, 26'h000_FFFC, 32'd0, 1, 32'h0000_6004, 0, 0, 0);
    endtask

    task automatic t_jump_r6();
        run("R6 jump fwd", 4'd5, 32'h0010_0000, 26'h1FF_FFFC, 32'h3, 0, 32'h0010_0004 + sx26(26'h1FF_FFFC), 1, 0, 0);
        run("R6 jump back", 4'd5, 32'h0010_0000, 26'h300_0000, 32'd0, 0, 32'h0010_0004 + sx26(26'h300_0000), 1, 0, 0);
    endtask

    task automatic t_reg_r7();
        run("R7 reg jump", 4'd6, 32'h0000_7000, 26'h000_0100, 32'hDEAD_BEE0, 0, 32'hDEAD_BEE0, 1, 0, 0);
    endtask

    task automatic t_link_r8();
        run("R8 jal", 4'd7, 32'h0000_8000, 26'h000_0010, 32'd0, 0, 32'h0000_8014, 1, 1, 0);
        run("R8 jalr", 4'd8, 32'h0000_8800, 26'h000_0000, 32'h0000_0400, 0, 32'h0000_0400, 1, 1, 0);
        run("R8 no link on taken branch", 4'd1, 32'h0000_8000, 26'h000_0010, 32'd0, 0, 32'h0000_8014, 1, 0, 0);
    endtask

    task automatic t_misalign_r9();
        run("R9 jr low bits", 4'd6, 32'h0000_9000, 26'd0, 32'h0000_0402, 0, 32'h0000_0402, 1, 0, 1);
        run("R9 jalr low bits", 4'd8, 32'h0000_9000, 26'd0, 32'h0000_0401, 0, 32'h0000_0401, 1, 1, 1);
        run("R9 direct ignores rs", 4'd5, 32'h0000_9000, 26'h000_0008, 32'h0000_0003, 0, 32'h0000_900C, 1, 0, 0);
    endtask

    task automatic t_idle_r10();
        run("R10 primer", 4'd7, 32'h0000_A000, 26'h000_0010, 32'h1, 0, 32'h0000_A014, 1, 1, 0);
        @(negedge clk);
        chk("R10 idle valid", 32'(out_valid), 0);
        chk("R10 idle taken", 32'(taken), 0);
        chk("R10 idle link_we", 32'(link_we), 0);
        chk("R10 idle misalign", 32'(misalign), 0);
    endtask

    task automatic t_wrap_r11();
        run("R11 wrap up", 4'd5, 32'hFFFF_FFF8, 26'h000_0010, 32'd0, 0, 32'h0000_000C, 1, 0, 0);
        run("R11 seq wrap", 4'd7, 32'hFFFF_FFFC, 26'h000_0000, 32'd0, 0, 32'h0000_0000, 1, 1, 0);
        run("R11 wrap down", 4'd1, 32'h0000_0000, 26'h3FF_FFF0, 32'd0, 0, 32'hFFFF_FFF4, 1, 0, 0);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        t_reset_r1();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_none_r2();
        t_zero_r3();
        t_nonzero_r4();
        t_fp_r5();
        t_jump_r6();
        t_reg_r7();
        t_link_r8();
        t_misalign_r9();
        t_idle_r10();
        t_wrap_r11();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule